// File: doc/BRIEF.md
# SCI Event Aggregator

This block holds the power-management event registers of a platform controller and turns them into a level-sensitive system control interrupt (SCI). Two independent sources feed the interrupt: a 16-bit PM1 status word masked by its enable word, and a small general-purpose event (GPE) block in which a single hotplug bit is the only one that can raise the line. Hardware events (timer overflow, power-button request, hotplug request) set status bits. Software clears them by writing ones.

The block also accepts writes to an APM command port. Two command codes turn ACPI mode on or off through the SCI-enable bit of the PM1 control word. Any command can raise a one-cycle system management interrupt (SMI) when the configuration input allows it. A timer-arm output tells the external free-running PM timer whether an overflow event is still wanted. The PM timer counter and the bus address decoding sit outside this block.

Top module: `sci_event_agg`

## Requirements
- R1: `sci` is high whenever PM1 status AND PM1 enable is nonzero in any of bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC). The other PM1 bits never affect `sci`.
- R2: `sci` is also high whenever bit 1 is set in both GPE status byte 0 and GPE enable byte 0. No other GPE bit affects `sci`.
- R3: `tmr_arm` is high exactly when PM1 enable bit 0 is set and PM1 status bit 0 is clear.
- R4: The GPE port is 32 bits wide with one write enable per byte. Byte lanes 0 and 1 are status bytes and are write-one-to-clear. Lanes 2 and 3 are enable bytes 0 and 1 and are plain read/write. `gpe_rdata` presents the same four bytes in the same lanes. Each enabled lane is written on its own, so a single write may touch any subset of the four bytes.
- R5: PM1 status is write-one-to-clear through `pm1_sts_wr` with `pm1_wdata`. `tmr_ovf` sets bit 0 and `pwrbtn_req` sets bit 8. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: `hotplug_req` sets bit 1 of GPE status byte 0. A set in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R7: An APM write of 0xF1 sets PM1 control bit 0 (SCI enable). A write of 0xF0 clears it. Any other value leaves the bit unchanged. When `pm1_cnt_wr` falls in the same cycle as such a command, the command decides bit 0 and the control write supplies the other bits.
- R8: `smi` is high for exactly the one cycle after an APM write made while `smi_cfg` bit 1 is set. At all other times it is low.
- R9: While reset is active, all registers read zero and `sci`, `smi` and `tmr_arm` are low.
- R10: PM1 enable and PM1 control are plain 16-bit read/write registers, loaded from `pm1_wdata` by `pm1_en_wr` and `pm1_cnt_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpe_wr | input | 1 | GPE block write strobe |
| gpe_be | input | 4 | GPE byte lane enables |
| gpe_wdata | input | 32 | GPE write data |
| gpe_rdata | output | 32 | GPE register contents |
| pm1_wdata | input | 16 | Write data shared by the PM1 registers |
| pm1_sts_wr | input | 1 | PM1 status write-one-to-clear strobe |
| pm1_en_wr | input | 1 | PM1 enable write strobe |
| pm1_cnt_wr | input | 1 | PM1 control write strobe |
| pm1_sts | output | 16 | PM1 status word |
| pm1_en | output | 16 | PM1 enable word |
| pm1_cnt | output | 16 | PM1 control word |
| tmr_ovf | input | 1 | PM timer overflow event |
| pwrbtn_req | input | 1 | Power-down request |
| hotplug_req | input | 1 | Hotplug event |
| apm_wr | input | 1 | APM command write strobe |
| apm_val | input | 8 | APM command value |
| smi_cfg | input | 8 | SMI configuration byte |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System management interrupt pulse |
| tmr_arm | output | 1 | Timer overflow request to the PM timer |

## Verification
Every register is visible at the ports, so a wrong status, enable or control bit shows up on the register outputs at the first comparison after the clock edge that produced it. It then reaches `sci` or `tmr_arm` in that same cycle, because both are computed combinationally from the registers. A lost set-over-clear priority shows as a status bit that reads zero right after a cycle in which an event and a clear collided. A bad SMI decision shows one cycle after the APM write, either as a missing pulse or as a pulse that lasts too long. The bench compares every output against a behavioural model on every clock, using directed collisions and a long random phase.

// File: rtl/sci_event_agg.sv
module sci_event_agg #(
  parameter int PM1_W      = 16,
  parameter int GPE_HALF   = 2,
  parameter int TMR_BIT    = 0,
  parameter int GBL_BIT    = 5,
  parameter int PWRBTN_BIT = 8,
  parameter int RTC_BIT    = 10,
  parameter int SCIEN_BIT  = 0,
  parameter int HP_BIT     = 1,
  parameter int SMICFG_BIT = 1,
  parameter logic [7:0] APM_ON  = 8'hF1,
  parameter logic [7:0] APM_OFF = 8'hF0,
  localparam int GPE_BYTES = 2 * GPE_HALF,
  localparam int GPE_W     = 8 * GPE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gpe_wr,
  input  logic [GPE_BYTES-1:0] gpe_be,
  input  logic [GPE_W-1:0]  gpe_wdata,
  output logic [GPE_W-1:0]  gpe_rdata,
  input  logic [PM1_W-1:0]  pm1_wdata,
  input  logic              pm1_sts_wr,
  input  logic              pm1_en_wr,
  input  logic              pm1_cnt_wr,
  output logic [PM1_W-1:0]  pm1_sts,
  output logic [PM1_W-1:0]  pm1_en,
  output logic [PM1_W-1:0]  pm1_cnt,
  input  logic              tmr_ovf,
  input  logic              pwrbtn_req,
  input  logic              hotplug_req,
  input  logic              apm_wr,
  input  logic [7:0]        apm_val,
  input  logic [7:0]        smi_cfg,
  output logic              sci,
  output logic              smi,
  output logic              tmr_arm
);

  localparam logic [PM1_W-1:0] SCI_MASK = PM1_W'((1 << TMR_BIT) | (1 << GBL_BIT) |
                                                 (1 << PWRBTN_BIT) | (1 << RTC_BIT));

  logic [PM1_W-1:0] sts_q, en_q, cnt_q, cnt_d, hw_set, sw_clr;
  logic             smi_q;
  logic             gpe_hit;

  assign hw_set = (tmr_ovf    ? PM1_W'(1 << TMR_BIT)    : '0) |
                  (pwrbtn_req ? PM1_W'(1 << PWRBTN_BIT) : '0);
  assign sw_clr = pm1_sts_wr ? pm1_wdata : '0;

  always_comb begin
    cnt_d = pm1_cnt_wr ? pm1_wdata : cnt_q;
    if (apm_wr && apm_val == APM_ON)  cnt_d[SCIEN_BIT] = 1'b1;
    if (apm_wr && apm_val == APM_OFF) cnt_d[SCIEN_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      cnt_q <= '0;
      smi_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~sw_clr) | hw_set;
      if (pm1_en_wr) en_q <= pm1_wdata;
      cnt_q <= cnt_d;
      smi_q <= apm_wr && smi_cfg[SMICFG_BIT];
    end
  end

  for (genvar i = 0; i < GPE_HALF; i++) begin : g_gpe
    logic [7:0] st_q, en_b_q, st_set, st_clr;
    assign st_set = (i == 0 && hotplug_req) ? 8'(1 << HP_BIT) : 8'h00;
    assign st_clr = (gpe_wr && gpe_be[i]) ? gpe_wdata[8*i +: 8] : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q   <= 8'h00;
        en_b_q <= 8'h00;
      end else begin
        st_q <= (st_q & ~st_clr) | st_set;
        if (gpe_wr && gpe_be[GPE_HALF+i]) en_b_q <= gpe_wdata[8*(GPE_HALF+i) +: 8];
      end
    end
    assign gpe_rdata[8*i +: 8]            = st_q;
    assign gpe_rdata[8*(GPE_HALF+i) +: 8] = en_b_q;
  end

  assign gpe_hit = g_gpe[0].st_q[HP_BIT] & g_gpe[0].en_b_q[HP_BIT];
  assign sci     = (|(sts_q & en_q & SCI_MASK)) | gpe_hit;
  assign tmr_arm = en_q[TMR_BIT] & ~sts_q[TMR_BIT];
  assign smi     = smi_q;
  assign pm1_sts = sts_q;
  assign pm1_en  = en_q;
  assign pm1_cnt = cnt_q;

  p_pwrbtn_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_req |=> pm1_sts[PWRBTN_BIT]);
  p_ovf_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> !tmr_arm);
  p_hotplug_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hotplug_req |=> gpe_rdata[HP_BIT]);
  p_hotplug_sci_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hotplug_req && gpe_rdata[8*GPE_HALF+HP_BIT] && !(gpe_wr && gpe_be[GPE_HALF])) |=> sci);
  p_apm_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_val == APM_ON) |=> pm1_cnt[SCIEN_BIT]);
  p_apm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_val == APM_OFF) |=> !pm1_cnt[SCIEN_BIT]);
  p_smi_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(apm_wr) && $past(smi_cfg[SMICFG_BIT]));
  p_smi_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_cfg[SMICFG_BIT] |=> !smi);

endmodule

// File: tb/sci_event_agg_bench.sv
module sci_event_agg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gpe_wr = 0;
  logic [3:0] gpe_be = 0;
  logic [31:0] gpe_wdata = 0;
  logic [31:0] gpe_rdata;
  logic [15:0] pm1_wdata = 0;
  logic pm1_sts_wr = 0, pm1_en_wr = 0, pm1_cnt_wr = 0;
  logic [15:0] pm1_sts, pm1_en, pm1_cnt;
  logic tmr_ovf = 0, pwrbtn_req = 0, hotplug_req = 0;
  logic apm_wr = 0;
  logic [7:0] apm_val = 0, smi_cfg = 0;
  logic sci, smi, tmr_arm;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_sts = 0, m_en = 0, m_cnt = 0, m_smi = 0;
  int m_gs[2] = '{0, 0};
  int m_ge[2] = '{0, 0};

  always #5 clk = ~clk;

  sci_event_agg u_sci_event_agg (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_cnt = 0; m_smi = 0;
      m_gs = '{0, 0}; m_ge = '{0, 0};
    end else begin
      m_smi = (apm_wr && smi_cfg[1]) ? 1 : 0;
      if (pm1_sts_wr) m_sts = m_sts & ~int'(pm1_wdata);
      if (tmr_ovf) m_sts = m_sts | 1;
      if (pwrbtn_req) m_sts = m_sts | 'h100;
      if (pm1_en_wr) m_en = pm1_wdata;
      if (pm1_cnt_wr) m_cnt = pm1_wdata;
      if (apm_wr && apm_val == 8'hF1) m_cnt = m_cnt | 1;
      if (apm_wr && apm_val == 8'hF0) m_cnt = m_cnt & 'hFFFE;
      for (int i = 0; i < 4; i++)
        if (gpe_wr && gpe_be[i]) begin
          if (i < 2) m_gs[i] = m_gs[i] & ~int'(gpe_wdata[8*i +: 8]);
          else m_ge[i-2] = gpe_wdata[8*i +: 8];
        end
      if (hotplug_req) m_gs[0] = m_gs[0] | 2;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int exp_sci;
      exp_sci = ((m_sts & m_en & 'h0521) != 0 || (m_gs[0] & m_ge[0] & 2) != 0) ? 1 : 0;
      check("R5 pm1_sts", int'(pm1_sts), m_sts);
      check("R10 pm1_en", int'(pm1_en), m_en);
      check("R7 pm1_cnt", int'(pm1_cnt), m_cnt);
      check("R4 R6 gpe_rdata", int'(gpe_rdata), (m_ge[1] << 24) | (m_ge[0] << 16) | (m_gs[1] << 8) | m_gs[0]);
      check("R1 R2 sci", int'(sci), exp_sci);
      check("R3 tmr_arm", int'(tmr_arm), ((m_en & 1) && !(m_sts & 1)) ? 1 : 0);
      check("R8 smi", int'(smi), m_smi);
    end
    if (cyc > 100000) begin
      check("watchdog", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    gpe_wr = 0; gpe_be = 0; pm1_sts_wr = 0; pm1_en_wr = 0; pm1_cnt_wr = 0;
    tmr_ovf = 0; pwrbtn_req = 0; hotplug_req = 0; apm_wr = 0;
  endtask

  task automatic wr_pm1(int which, logic [15:0] d);
    pm1_wdata = d;
    if (which == 0) pm1_sts_wr = 1; else if (which == 1) pm1_en_wr = 1; else pm1_cnt_wr = 1;
    tick();
  endtask

  task automatic wr_gpe(logic [3:0] be, logic [31:0] d);
    gpe_wr = 1; gpe_be = be; gpe_wdata = d; tick();
  endtask

  task automatic apm(logic [7:0] v, logic [7:0] cfg);
    apm_wr = 1; apm_val = v; smi_cfg = cfg; tick();
  endtask

  initial begin
    pm1_wdata = 16'hFFFF; pm1_en_wr = 1; pm1_cnt_wr = 1; gpe_wr = 1; gpe_be = 4'hF;
    gpe_wdata = '1; tmr_ovf = 1; hotplug_req = 1; apm_wr = 1; apm_val = 8'hF1; smi_cfg = 8'h02;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset sci", int'(sci), 0);
    check("R9 reset smi", int'(smi), 0);
    check("R9 reset tmr_arm", int'(tmr_arm), 0);
    check("R9 reset regs", int'(|{pm1_sts, pm1_en, pm1_cnt, gpe_rdata}), 0);
    #2; tick(); smi_cfg = 0;
    rst_n = 1; tick();
    // R3 R1 timer path
    wr_pm1(1, 16'h0001);
    tmr_ovf = 1; tick();
    wr_pm1(0, 16'h0001);
    tmr_ovf = 1; pm1_sts_wr = 1; pm1_wdata = 16'h0001; tick();
    wr_pm1(0, 16'hFFFF);
    // R1 power button and out-of-mask enables
    wr_pm1(1, 16'hFAFE);
    pwrbtn_req = 1; tick();
    wr_pm1(1, 16'h0100);
    pwrbtn_req = 1; pm1_sts_wr = 1; pm1_wdata = 16'h0100; tick();
    wr_pm1(0, 16'h0100);
    // R2 R4 R6 GPE path
    wr_gpe(4'b0100, 32'h00FD_0000);
    hotplug_req = 1; tick();
    wr_gpe(4'b1100, 32'h5A02_0000);
    wr_gpe(4'b0010, 32'h0000_FF00);
    gpe_wr = 1; gpe_be = 4'b0001; gpe_wdata = 32'h2; hotplug_req = 1; tick();
    wr_gpe(4'b0001, 32'h0000_00FD);
    wr_gpe(4'b0001, 32'h0000_0002);
    wr_gpe(4'b1111, 32'hFFFF_FFFF);
    // R7 R8 APM
    apm(8'hF1, 8'h02); tick();
    apm(8'h55, 8'h02);
    apm(8'hF0, 8'h00);
    apm(8'hF1, 8'hFD);
    pm1_cnt_wr = 1; pm1_wdata = 16'hA5A4; apm_wr = 1; apm_val = 8'hF1; smi_cfg = 8'h02; tick();
    pm1_cnt_wr = 1; pm1_wdata = 16'hFFFF; apm_wr = 1; apm_val = 8'hF0; tick();
    wr_pm1(2, 16'h1234);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      tmr_ovf = (r < 8); pwrbtn_req = (r % 11 == 0); hotplug_req = (r % 13 == 0);
      pm1_wdata = 16'($urandom);
      pm1_sts_wr = ($urandom_range(0, 5) == 0);
      pm1_en_wr = ($urandom_range(0, 9) == 0);
      pm1_cnt_wr = ($urandom_range(0, 9) == 0);
      gpe_wr = ($urandom_range(0, 4) == 0); gpe_be = 4'($urandom); gpe_wdata = $urandom;
      apm_wr = ($urandom_range(0, 6) == 0);
      apm_val = ($urandom_range(0, 2) == 0) ? 8'hF1 : (($urandom_range(0, 1) == 0) ? 8'hF0 : 8'($urandom));
      smi_cfg = 8'($urandom);
      tick();
    end
    repeat (3) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule